// File: doc/BRIEF.md
# Miss Target Queue with Deferred Promotion

This block holds the requests that wait on a single outstanding cache miss. It keeps them in two ordered lists. The active list holds the targets that the fill now in flight will serve. The deferred list holds the targets that fill cannot serve. Each target carries a tag, a source (CPU, another cache, a snoop or the prefetcher) and four attribute bits: needs-writable, cache-maintenance, allocate-on-fill and upgrade.

The owner drives one operation per cycle. An add places a target at the tail of either list. Two promotion commands move targets from the deferred head to the active tail. A start marks the entry as in service. Two response kinds remove targets that a fill has served: a plain response serves the whole active list, and a response that carries an unexpected invalidate serves only part of it.

Each target records whether its upstream pending indication has already been cleared. The block reports how many such clears each operation issues, so that no target is ever cleared twice. Summary flags are always the OR of the targets now on the active list.

Top module: `miss_target_queue`

## Requirements
- R1: After reset both lists are empty, every summary flag is 0, `clr_cnt` is 0 and `svc_mask` is 0.
- R2: An add that is not stalled appends its target at the tail of the list chosen by `add_defer` (1 = deferred). `act_tags` shows active targets in arrival order, slot 0 oldest, tag of slot i at bits [i*TAG_W +: TAG_W].
- R3: An add to a list that already holds DEPTH targets raises `add_stall` in the same cycle and changes neither list.
- R4: Op 2 (promote readable) moves deferred targets, head first and in order, to the active tail. It stops at the first deferred target with needs-writable or cache-maintenance set, or when the active list is full.
- R5: Op 3 (promote all) moves deferred targets in order until the deferred list is empty or the active list is full.
- R6: `flag_writable`, `flag_upgrade` and `flag_alloc` are the OR of that attribute over the active targets. `flag_from_cache` is set when any active target has source 1 (cache). The source codes are 0 CPU, 1 cache, 2 snoop and 3 prefetcher. The flags follow every promotion and removal.
- R7: Op 5 (response) serves every active target. `svc_mask` bit i is set for each occupied slot i, the active list empties, and the entry leaves service.
- R8: Op 6 (response with invalidate) serves only the oldest CPU-sourced target and all snoop-sourced targets. `svc_mask` marks their slots before removal, and the other active targets stay in their original order.
- R9: `clr_cnt` counts targets whose pending clear is issued by the operation. An active add while in service gives 1. Op 4 (start) gives the number of active targets not yet cleared. A promotion while in service gives the number moved. A target is never counted twice, so a repeated start gives 0.
- R10: `tgt_total` equals `act_cnt` plus `def_cnt` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | 0 idle, 1 add, 2 promote readable, 3 promote all, 4 start, 5 response, 6 response with invalidate |
| add_tag | input | TAG_W | Tag of the target being added |
| add_src | input | 2 | Source: 0 CPU, 1 cache, 2 snoop, 3 prefetcher |
| add_writable | input | 1 | Target needs a writable copy |
| add_maint | input | 1 | Target is a cache-maintenance operation |
| add_alloc | input | 1 | Target asks to allocate on fill |
| add_upgrade | input | 1 | Target is an upgrade |
| add_defer | input | 1 | 1 places the target on the deferred list |
| add_stall | output | 1 | Add refused because the chosen list is full |
| act_cnt | output | CNT_W | Active list occupancy |
| def_cnt | output | CNT_W | Deferred list occupancy |
| tgt_total | output | TOT_W | Sum of both occupancies |
| act_tags | output | DEPTH*TAG_W | Active tags in order |
| flag_writable | output | 1 | Some active target needs writable |
| flag_upgrade | output | 1 | Some active target is an upgrade |
| flag_alloc | output | 1 | Some active target allocates on fill |
| flag_from_cache | output | 1 | Some active target comes from a cache |
| clr_cnt | output | CNT_W | Pending clears issued by the previous operation |
| svc_mask | output | DEPTH | Active slots served by the previous response |

## Verification
`add_stall` is combinational and is due in the same cycle as the add, so the bench samples it after the inputs settle and before the clock edge. Every other result is due one edge after the operation. The occupancies, tags and flags come from the updated state, and `clr_cnt` and `svc_mask` come from their own registers. The bench therefore samples these at the falling edge after that rising edge, and compares them with a queue model that it advances at the same operation.

// File: rtl/mtq_pkg.sv
// Shared types for the miss target queue.
// Assumes one operation per cycle, chosen by the op code.
package mtq_pkg;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_CACHE = 2'd1,
        SRC_SNOOP = 2'd2,
        SRC_PREF  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_ADD      = 3'd1,
        OP_PROM_RD  = 3'd2,
        OP_PROM_ALL = 3'd3,
        OP_START    = 3'd4,
        OP_RESP     = 3'd5,
        OP_RESP_INV = 3'd6
    } op_e;

    typedef struct packed {
        src_e src;
        logic writable;
        logic maint;
        logic alloc;
        logic upgrade;
    } attr_t;

endpackage

// File: rtl/mtq_promote_sel.sv
// Counts how many deferred targets a promotion moves.
// It walks from the deferred head and stops at the first target that fails
// the condition or when the active list has no room left.
// Assumes blk[i] is valid only for i < def_cnt.
module mtq_promote_sel #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] blk,
    input  logic [CNT_W-1:0] def_cnt,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic             only_readable,
    output logic [CNT_W-1:0] prom_n
);
    int  n;
    logic stop;

    // Scan from the head, counting the run of entries that may move.
    always_comb begin
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && (i < int'(def_cnt)) && (n < DEPTH - int'(act_cnt)) &&
                !(only_readable && blk[i])) begin
                n = n + 1;
            end else begin
                stop = 1'b1;
            end
        end
        prom_n = CNT_W'(n);
    end
endmodule

// File: rtl/mtq_resp_sel.sv
// Picks the active slots that a response serves.
// A plain response serves all occupied slots. A response with invalidate
// serves only the oldest CPU target and every snoop target.
module mtq_resp_sel #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] is_cpu,
    input  logic [DEPTH-1:0] is_snoop,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic             inval,
    output logic [DEPTH-1:0] serve
);
    logic found;

    // Mark the served slots in order, so that only one CPU target is taken.
    always_comb begin
        serve = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(act_cnt)) begin
                if (!inval || is_snoop[i]) begin
                    serve[i] = 1'b1;
                end else if (is_cpu[i] && !found) begin
                    serve[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtq_flags.sv
// Summary flags: the OR of each attribute over the occupied active slots.
module mtq_flags #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] wr,
    input  logic [DEPTH-1:0] up,
    input  logic [DEPTH-1:0] al,
    input  logic [DEPTH-1:0] fc,
    input  logic [CNT_W-1:0] act_cnt,
    output logic             f_wr,
    output logic             f_up,
    output logic             f_al,
    output logic             f_fc
);
    // Reduce each attribute over the occupied prefix of the list.
    always_comb begin
        f_wr = 1'b0;
        f_up = 1'b0;
        f_al = 1'b0;
        f_fc = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(act_cnt)) begin
                f_wr = f_wr | wr[i];
                f_up = f_up | up[i];
                f_al = f_al | al[i];
                f_fc = f_fc | fc[i];
            end
        end
    end
endmodule

// File: rtl/miss_target_queue.sv
// Target lists for one outstanding miss: an active list and a deferred list.
// Each list is an ordered array with slot 0 as its head. The block takes one
// operation per cycle. It tracks which targets have had their upstream
// pending clear issued, so that the clear for a target happens only once.
// Assumes DEPTH >= 2. Synchronous active-low reset.
module miss_target_queue
    import mtq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TOT_W = $clog2(2 * DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op,
    input  logic [TAG_W-1:0]       add_tag,
    input  logic [1:0]             add_src,
    input  logic                   add_writable,
    input  logic                   add_maint,
    input  logic                   add_alloc,
    input  logic                   add_upgrade,
    input  logic                   add_defer,
    output logic                   add_stall,
    output logic [CNT_W-1:0]       act_cnt,
    output logic [CNT_W-1:0]       def_cnt,
    output logic [TOT_W-1:0]       tgt_total,
    output logic [DEPTH*TAG_W-1:0] act_tags,
    output logic                   flag_writable,
    output logic                   flag_upgrade,
    output logic                   flag_alloc,
    output logic                   flag_from_cache,
    output logic [CNT_W-1:0]       clr_cnt,
    output logic [DEPTH-1:0]       svc_mask
);
    localparam int IDX_W = $clog2(DEPTH);

    op_e        op_q;
    attr_t      new_attr;
    attr_t      a_attr [DEPTH];
    attr_t      d_attr [DEPTH];
    logic [TAG_W-1:0] a_tag [DEPTH];
    logic [TAG_W-1:0] d_tag [DEPTH];
    logic [DEPTH-1:0] a_pend;
    logic             in_svc;

    attr_t      n_a_attr [DEPTH];
    attr_t      n_d_attr [DEPTH];
    logic [TAG_W-1:0] n_a_tag [DEPTH];
    logic [TAG_W-1:0] n_d_tag [DEPTH];
    logic [DEPTH-1:0] n_a_pend;
    logic             n_in_svc;
    logic [CNT_W-1:0] n_act_cnt, n_def_cnt, n_clr, prom_n;
    logic [DEPTH-1:0] n_mask, serve, d_blk, a_cpu, a_snp, a_wr, a_up, a_al, a_fc;

    assign op_q     = op_e'(op);
    assign new_attr = '{src: src_e'(add_src), writable: add_writable,
                        maint: add_maint, alloc: add_alloc, upgrade: add_upgrade};

    // Refuse an add whose chosen list is full.
    assign add_stall = (op_q == OP_ADD) &&
                       (add_defer ? (def_cnt == CNT_W'(DEPTH)) : (act_cnt == CNT_W'(DEPTH)));

    // Split the per-slot attributes out for the selection helpers.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            assign d_blk[g] = d_attr[g].maint | d_attr[g].writable;
            assign a_cpu[g] = (a_attr[g].src == SRC_CPU);
            assign a_snp[g] = (a_attr[g].src == SRC_SNOOP);
            assign a_fc[g]  = (a_attr[g].src == SRC_CACHE);
            assign a_wr[g]  = a_attr[g].writable;
            assign a_up[g]  = a_attr[g].upgrade;
            assign a_al[g]  = a_attr[g].alloc;
            assign act_tags[g*TAG_W +: TAG_W] = a_tag[g];
        end
    endgenerate

    mtq_promote_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_prom (
        .blk(d_blk), .def_cnt(def_cnt), .act_cnt(act_cnt),
        .only_readable(op_q == OP_PROM_RD), .prom_n(prom_n));

    mtq_resp_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_resp (
        .is_cpu(a_cpu), .is_snoop(a_snp), .act_cnt(act_cnt),
        .inval(op_q == OP_RESP_INV), .serve(serve));

    mtq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .wr(a_wr), .up(a_up), .al(a_al), .fc(a_fc), .act_cnt(act_cnt),
        .f_wr(flag_writable), .f_up(flag_upgrade), .f_al(flag_alloc),
        .f_fc(flag_from_cache));

    assign tgt_total = TOT_W'(act_cnt) + TOT_W'(def_cnt);

    int s;
    int w;
    int c;

    // Next-state of both lists for the current operation.
    always_comb begin
        n_a_attr  = a_attr;
        n_a_tag   = a_tag;
        n_a_pend  = a_pend;
        n_d_attr  = d_attr;
        n_d_tag   = d_tag;
        n_act_cnt = act_cnt;
        n_def_cnt = def_cnt;
        n_in_svc  = in_svc;
        n_clr     = '0;
        n_mask    = '0;
        s = 0;
        w = 0;
        c = 0;
        case (op_q)
            OP_ADD: begin
                if (!add_stall) begin
                    if (add_defer) begin
                        n_d_attr[def_cnt[IDX_W-1:0]] = new_attr;
                        n_d_tag[def_cnt[IDX_W-1:0]]  = add_tag;
                        n_def_cnt = def_cnt + 1'b1;
                    end else begin
                        n_a_attr[act_cnt[IDX_W-1:0]] = new_attr;
                        n_a_tag[act_cnt[IDX_W-1:0]]  = add_tag;
                        n_a_pend[act_cnt[IDX_W-1:0]] = in_svc;
                        n_act_cnt = act_cnt + 1'b1;
                        n_clr     = CNT_W'(in_svc);
                    end
                end
            end
            OP_PROM_RD, OP_PROM_ALL: begin
                for (int i = 0; i < DEPTH; i++) begin
                    s = i - int'(act_cnt);
                    if (s >= 0 && s < int'(prom_n)) begin
                        n_a_attr[i] = d_attr[IDX_W'(s)];
                        n_a_tag[i]  = d_tag[IDX_W'(s)];
                        n_a_pend[i] = in_svc;
                    end
                    if (i + int'(prom_n) < DEPTH) begin
                        n_d_attr[i] = d_attr[IDX_W'(i + int'(prom_n))];
                        n_d_tag[i]  = d_tag[IDX_W'(i + int'(prom_n))];
                    end
                end
                n_act_cnt = act_cnt + prom_n;
                n_def_cnt = def_cnt - prom_n;
                n_clr     = in_svc ? prom_n : '0;
            end
            OP_START: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < int'(act_cnt) && !a_pend[i]) begin
                        c = c + 1;
                        n_a_pend[i] = 1'b1;
                    end
                end
                n_clr    = CNT_W'(c);
                n_in_svc = 1'b1;
            end
            OP_RESP, OP_RESP_INV: begin
                n_mask = serve;
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < int'(act_cnt) && !serve[i]) begin
                        n_a_attr[IDX_W'(w)] = a_attr[i];
                        n_a_tag[IDX_W'(w)]  = a_tag[i];
                        n_a_pend[IDX_W'(w)] = a_pend[i];
                        w = w + 1;
                    end
                end
                n_act_cnt = CNT_W'(w);
                if (op_q == OP_RESP) begin
                    n_in_svc = 1'b0;
                end
            end
            default: ;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                a_attr[i] <= '0;
                d_attr[i] <= '0;
                a_tag[i]  <= '0;
                d_tag[i]  <= '0;
            end
            a_pend   <= '0;
            act_cnt  <= '0;
            def_cnt  <= '0;
            in_svc   <= 1'b0;
            clr_cnt  <= '0;
            svc_mask <= '0;
        end else begin
            a_attr   <= n_a_attr;
            d_attr   <= n_d_attr;
            a_tag    <= n_a_tag;
            d_tag    <= n_d_tag;
            a_pend   <= n_a_pend;
            act_cnt  <= n_act_cnt;
            def_cnt  <= n_def_cnt;
            in_svc   <= n_in_svc;
            clr_cnt  <= n_clr;
            svc_mask <= n_mask;
        end
    end

    AST_ADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_ADD && !add_stall && !add_defer) |=> act_cnt == $past(act_cnt) + 1'b1); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_ADD && add_stall) |=> ($stable(act_cnt) && $stable(def_cnt))); // R3
    AST_PROM_KEEPS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_PROM_RD || op_q == OP_PROM_ALL) |=> tgt_total == $past(tgt_total)); // R4
    AST_RESP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RESP) |=> act_cnt == '0); // R7
    AST_INV_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RESP_INV) |=> int'(act_cnt) == int'($past(act_cnt)) - $countones(svc_mask)); // R8
    AST_CLR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt <= act_cnt); // R9
endmodule

// File: tb/miss_target_queue_tb.sv
`timescale 1ns/100ps
module miss_target_queue_tb;
    localparam int D = 4;

    typedef struct {
        logic [3:0] tag;
        logic [1:0] src;
        logic wr, mt, al, up, pd;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic [3:0] add_tag = '0;
    logic [1:0] add_src = '0;
    logic add_writable = 0, add_maint = 0, add_alloc = 0, add_upgrade = 0, add_defer = 0;
    logic add_stall;
    logic [2:0] act_cnt, def_cnt;
    logic [3:0] tgt_total;
    logic [15:0] act_tags;
    logic flag_writable, flag_upgrade, flag_alloc, flag_from_cache;
    logic [2:0] clr_cnt;
    logic [3:0] svc_mask;

    int n_chk = 0;
    int n_bad = 0;
    ent_t mact[$];
    ent_t mdef[$];
    bit   minsvc = 0;
    int   exp_clr = 0;
    int   exp_mask = 0;

    always #2.5 clk = ~clk;

    miss_target_queue #(.DEPTH(D), .TAG_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .add_tag(add_tag), .add_src(add_src),
        .add_writable(add_writable), .add_maint(add_maint), .add_alloc(add_alloc),
        .add_upgrade(add_upgrade), .add_defer(add_defer), .add_stall(add_stall),
        .act_cnt(act_cnt), .def_cnt(def_cnt), .tgt_total(tgt_total), .act_tags(act_tags),
        .flag_writable(flag_writable), .flag_upgrade(flag_upgrade), .flag_alloc(flag_alloc),
        .flag_from_cache(flag_from_cache), .clr_cnt(clr_cnt), .svc_mask(svc_mask));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every registered output with the model.
    task automatic check_state();
        int fw = 0, fu = 0, fa = 0, fc = 0;
        foreach (mact[i]) begin
            fw |= mact[i].wr; fu |= mact[i].up; fa |= mact[i].al;
            fc |= (mact[i].src == 2'd1);
            chk("R2 active tag order", int'(act_tags[i*4 +: 4]), int'(mact[i].tag));
        end
        chk("R2 act_cnt", int'(act_cnt), mact.size());
        chk("R2 def_cnt", int'(def_cnt), mdef.size());
        chk("R10 total", int'(tgt_total), mact.size() + mdef.size());
        chk("R6 writable flag", int'(flag_writable), fw);
        chk("R6 upgrade flag", int'(flag_upgrade), fu);
        chk("R6 alloc flag", int'(flag_alloc), fa);
        chk("R6 from-cache flag", int'(flag_from_cache), fc);
        chk("R9 clr_cnt", int'(clr_cnt), exp_clr);
        chk("R7 R8 svc_mask", int'(svc_mask), exp_mask);
    endtask

    // Apply one operation at a falling edge, advance the model, then check.
    task automatic apply(int o, int tg, int sr, bit wr, bit mt, bit al, bit up, bit df);
        ent_t e;
        bit full;
        bit found;
        ent_t keep[$];
        op = 3'(o); add_tag = 4'(tg); add_src = 2'(sr);
        add_writable = wr; add_maint = mt; add_alloc = al; add_upgrade = up; add_defer = df;
        #1;
        full = (o == 1) && (df ? (mdef.size() == D) : (mact.size() == D));
        chk("R3 add_stall", int'(add_stall), int'(full));
        exp_clr = 0; exp_mask = 0;
        case (o)
            1: if (!full) begin
                e.tag = 4'(tg); e.src = 2'(sr); e.wr = wr; e.mt = mt; e.al = al; e.up = up;
                if (df) begin e.pd = 0; mdef.push_back(e); end
                else begin e.pd = minsvc; exp_clr = int'(minsvc); mact.push_back(e); end
            end
            2, 3: while (mdef.size() > 0 && mact.size() < D &&
                         !(o == 2 && (mdef[0].mt || mdef[0].wr))) begin
                e = mdef.pop_front();
                e.pd = minsvc;
                if (minsvc) exp_clr++;
                mact.push_back(e);
            end
            4: begin
                foreach (mact[i]) if (!mact[i].pd) begin mact[i].pd = 1; exp_clr++; end
                minsvc = 1;
            end
            5: begin
                exp_mask = (1 << mact.size()) - 1;
                mact.delete();
                minsvc = 0;
            end
            6: begin
                found = 0;
                foreach (mact[i]) begin
                    if (mact[i].src == 2'd2 || (mact[i].src == 2'd0 && !found)) begin
                        if (mact[i].src == 2'd0) found = 1;
                        exp_mask |= (1 << i);
                    end else keep.push_back(mact[i]);
                end
                mact = keep;
            end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        op = 3'd0;
        check_state();
    endtask

    initial begin
        #(5 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state();
        // R4: readable promotion stops at the maintenance target
        apply(1, 1, 0, 0, 0, 1, 0, 1);
        apply(1, 2, 1, 0, 0, 0, 0, 1);
        apply(1, 3, 0, 0, 1, 0, 0, 1);
        apply(1, 4, 2, 0, 0, 0, 0, 1);
        apply(1, 5, 0, 0, 0, 0, 0, 1); // R3 deferred full
        apply(2, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 moved two", int'(act_cnt), 2);
        apply(2, 0, 0, 0, 0, 0, 0, 0); // R4 blocked head moves nothing
        // R9: start clears both, repeat clears none
        apply(4, 0, 0, 0, 0, 0, 0, 0);
        apply(4, 0, 0, 0, 0, 0, 0, 0);
        // R5: promote all fills active
        apply(3, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 6, 0, 0, 0, 0, 0, 0); // R3 active full
        // R8: invalidating response, partial service
        apply(6, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 7, 0, 1, 0, 0, 1, 0);
        apply(1, 8, 2, 0, 0, 0, 0, 0);
        apply(6, 0, 0, 0, 0, 0, 0, 0);
        // R7: full response
        apply(5, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 800; k++) begin
            int r = $urandom_range(0, 15);
            int o = (r < 7) ? 1 : (r < 9) ? 2 : (r < 11) ? 3 : (r < 12) ? 4 : (r < 13) ? 5 : (r < 15) ? 6 : 0;
            apply(o, $urandom_range(0, 15), $urandom_range(0, 3), 1'($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule